// File: doc/BRIEF.md
# Power-Down Hold Controller

This block sits between a device's pins and its core logic and implements a pin-controlled freeze. When the feature's configuration bit is set and the power-down pin is high, the controller stops passing pin transitions into the core. It also holds every pad output value and every pad drive enable where they were, so a pad that was not driving stays undriven. When the pin returns low, the frozen input image is replaced by the live pin values on a clock edge, and the pads follow the core again.

The power-down pin first passes through a synchronizer of `SYNC_STAGES` flops. Ordinary input pins are registered once before they reach the core. When the feature is enabled, the power-down pin is a control pin only and the core sees a constant zero in its place. When the feature is disabled, the pin is treated as one more registered input.

A separate idle detector raises a standby flag after `IDLE_CYCLES` consecutive clock edges in which nothing new reached the core. A transition that the freeze blocks does not count as activity.

Top module: `pd_hold_ctrl`

## Requirements
- R1: While `rst_ni` is low: `core_in_o`, `core_pd_pin_o` and `standby_o` are 0, and the pads are live, so `pad_out_o` equals `core_out_i` and `pad_oe_o` equals `core_oe_i`.
- R2: With no freeze in effect, `core_in_o` shows `pins_i` as sampled at the previous rising edge, and `pad_out_o`/`pad_oe_o` follow `core_out_i`/`core_oe_i` in the same cycle.
- R3: With `pd_en_i` = 1, `core_pd_pin_o` is 0. With `pd_en_i` = 0, it shows `pd_pin_i` as sampled at the previous rising edge, and the pin never causes a freeze.
- R4: A freeze takes effect at the first edge after `pd_pin_i` has been seen high by `SYNC_STAGES` edges. With 2 stages, `core_in_o` still takes new pin values at the first two edges after the rise and is frozen from the third.
- R5: While frozen, `core_in_o` keeps its value regardless of any change on `pins_i`.
- R6: At the edge where the freeze takes effect, `pad_out_o` is captured from `core_out_i` and then held until release.
- R7: `pad_oe_o` (1 = pad driven, 0 = high impedance) is captured and held the same way. A pad that was undriven at freeze stays undriven.
- R8: After `pd_pin_i` falls, the block stays frozen for `SYNC_STAGES` edges. At the next edge `core_in_o` takes the live pins and the pads go live again.
- R9: `standby_o` rises after `IDLE_CYCLES` consecutive edges without activity. Activity is a non-frozen edge where `pins_i` differs from `core_in_o`, or, with `pd_en_i` = 0, a change on `pd_pin_i` relative to `core_pd_pin_o`.
- R10: `standby_o` falls at the first edge with activity. Pin changes blocked by a freeze, and power-down pin changes while the feature is enabled, are not activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_en_i | input | 1 | Configuration bit enabling pin-controlled freeze |
| pd_pin_i | input | 1 | Power-down pin, high requests freeze |
| pins_i | input | N_IN | Input pins |
| core_out_i | input | N_OUT | Output data from the core |
| core_oe_i | input | N_OUT | Output drive enables from the core (1 = drive) |
| core_in_o | output | N_IN | Gated, registered pin values presented to the core |
| core_pd_pin_o | output | 1 | Power-down pin as a logic input (0 when feature enabled) |
| pad_out_o | output | N_OUT | Pad output data, held while frozen |
| pad_oe_o | output | N_OUT | Pad drive enables, held while frozen |
| standby_o | output | 1 | Idle standby flag |

## Verification
Random pin, core-output and power-down-pin traffic runs with the feature both disabled and enabled. This separates plain pass-through, use of the pin as an ordinary input, and real freezes. Directed sequences change the pins on every edge around the power-down pin's rise and fall, which fixes the exact edges where capture stops and resumes. Outputs are forced undriven before a freeze to show that high impedance is kept. Quiet stretches of known length, and toggling that a freeze blocks, show that the standby counter sees only activity that reaches the core.

// File: rtl/pd_hold_pkg.sv
package pd_hold_pkg;
  typedef enum logic {
    PD_LIVE = 1'b0,
    PD_HELD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pd_in_gate.sv
module pd_in_gate #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pd_en_i,
  input  logic            pd_req_i,
  input  logic [N_IN-1:0] pins_i,
  input  logic            pd_pin_i,
  output logic [N_IN-1:0] core_in_o,
  output logic            core_pd_pin_o,
  output logic            activity_o
);
  logic [N_IN-1:0] in_q;
  logic            pdp_q;

  // per-pin capture, blocked while frozen
  for (genvar i = 0; i < N_IN; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        in_q[i] <= 1'b0;
      else if (!pd_req_i) in_q[i] <= pins_i[i];
    end
  end

  // pd pin is removed from logic use when the feature is on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pdp_q <= 1'b0;
    else         pdp_q <= pd_pin_i & ~pd_en_i;
  end

  assign core_in_o     = in_q;
  assign core_pd_pin_o = pdp_q;
  assign activity_o    = (~pd_req_i & (pins_i != in_q)) |
                         (~pd_en_i & (pd_pin_i != pdp_q));

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_i |=> $stable(core_in_o));
  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_req_i |=> core_in_o == $past(pins_i));
  assert_pin_hidden_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_i |=> !core_pd_pin_o);
endmodule

// File: rtl/pd_out_hold.sv
module pd_out_hold
  import pd_hold_pkg::*;
#(
  parameter int unsigned N_OUT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o
);
  hold_state_e      st_q;
  logic [N_OUT-1:0] out_q;
  logic [N_OUT-1:0] oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PD_LIVE;
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      // shadow tracks the core while live; freezes on the entry edge value
      if (st_q == PD_LIVE) begin
        out_q <= core_out_i;
        oe_q  <= core_oe_i;
      end
      st_q <= pd_req_i ? PD_HELD : PD_LIVE;
    end
  end

  assign pad_out_o = (st_q == PD_HELD) ? out_q : core_out_i;
  assign pad_oe_o  = (st_q == PD_HELD) ? oe_q  : core_oe_i;

  assert_data_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PD_HELD) && pd_req_i |=> $stable(pad_out_o));
  assert_hiz_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PD_HELD) && pd_req_i && (pad_oe_o == '0) |=> pad_oe_o == '0);
  assert_released_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_req_i |=> st_q == PD_LIVE);
endmodule

// File: rtl/pd_idle_det.sv
module pd_idle_det #(
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic activity_i,
  output logic standby_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (activity_i)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign standby_o = (cnt_q == LIMIT);

  assert_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> !standby_o);
  assert_sleep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT - 1'b1) && !activity_i |=> standby_o);
endmodule

// File: rtl/pd_hold_ctrl.sv
module pd_hold_ctrl #(
  parameter int unsigned N_IN        = 8,
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_en_i,
  input  logic             pd_pin_i,
  input  logic [N_IN-1:0]  pins_i,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_IN-1:0]  core_in_o,
  output logic             core_pd_pin_o,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o,
  output logic             standby_o
);
  logic pd_sync;
  logic pd_req;
  logic activity;

  pd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_pin_i),
    .q_o   (pd_sync)
  );

  assign pd_req = pd_en_i & pd_sync;

  pd_in_gate #(.N_IN(N_IN)) i_in_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_en_i      (pd_en_i),
    .pd_req_i     (pd_req),
    .pins_i       (pins_i),
    .pd_pin_i     (pd_pin_i),
    .core_in_o    (core_in_o),
    .core_pd_pin_o(core_pd_pin_o),
    .activity_o   (activity)
  );

  pd_out_hold #(.N_OUT(N_OUT)) i_out_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_req_i  (pd_req),
    .core_out_i(core_out_i),
    .core_oe_i (core_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  pd_idle_det #(.IDLE_CYCLES(IDLE_CYCLES)) i_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .activity_i(activity),
    .standby_o (standby_o)
  );

  assert_no_req_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_en_i |-> !pd_req);
  assert_gated_input_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_en_i && pd_sync |=> $stable(core_in_o));
endmodule

// File: tb/test_pd_hold_ctrl.sv
module test_pd_hold_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int SY = 2;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pin = 1'b0;
  logic [NI-1:0] pins = '0;
  logic [NO-1:0] cout = '0, coe = '0;
  logic [NI-1:0] core_in;
  logic core_pdp, standby;
  logic [NO-1:0] pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  pd_hold_ctrl #(.N_IN(NI), .N_OUT(NO), .SYNC_STAGES(SY), .IDLE_CYCLES(IDLE)) i_pd_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pd_en_i(en), .pd_pin_i(pin), .pins_i(pins),
    .core_out_i(cout), .core_oe_i(coe), .core_in_o(core_in),
    .core_pd_pin_o(core_pdp), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .standby_o(standby)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  bit [SY-1:0] m_s;
  bit [NI-1:0] m_in;
  bit m_pdp, m_hold, mreq, mchg;
  bit [NO-1:0] m_out, m_oe;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = '0; m_in = '0; m_pdp = 0; m_hold = 0; m_out = '0; m_oe = '0; m_cnt = 0;
    end else begin
      mreq = en && m_s[SY-1];
      mchg = (!mreq && (pins != m_in)) || (!en && (pin != m_pdp));
      if (!mreq) m_in = pins;
      m_pdp = en ? 1'b0 : pin;
      if (!m_hold) begin m_out = cout; m_oe = coe; end
      m_hold = mreq;
      m_cnt = mchg ? 0 : ((m_cnt < IDLE) ? m_cnt + 1 : m_cnt);
      m_s = {m_s[SY-2:0], pin};
    end
  end

  function automatic logic [NO-1:0] exp_pad(input bit held, input logic [NO-1:0] hv, input logic [NO-1:0] lv);
    return held ? hv : lv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(m_hold ? "R5 core_in frozen" : "R2 core_in pass", 32'(core_in), 32'(m_in));
    chk("R3 core_pd_pin", 32'(core_pdp), 32'(m_pdp));
    chk(m_hold ? "R6 pad_out held" : "R2 pad_out live", 32'(pad_out), 32'(exp_pad(m_hold, m_out, cout)));
    chk("R7 pad_oe", 32'(pad_oe), 32'(exp_pad(m_hold, m_oe, coe)));
    chk((m_cnt == IDLE) ? "R9 standby" : "R10 standby", 32'(standby), 32'(m_cnt == IDLE));
  endtask

  task automatic rand_run(input int n, input bit en_v, input int pd_odds);
    int quiet = 0;
    en = en_v;
    for (int c = 0; c < n; c++) begin
      step();
      cout = NO'($urandom); coe = NO'($urandom);
      if (quiet > 0) quiet--;
      else begin
        if ($urandom % 20 == 0) quiet = IDLE + 2 + int'($urandom % 8);
        else if ($urandom % 2 == 0) pins = NI'($urandom);
        if ($urandom % pd_odds == 0) pin = ~pin;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    cout = 8'h5A; coe = 8'hF0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 core_in", 32'(core_in), 0);
    chk("R1 core_pd_pin", 32'(core_pdp), 0);
    chk("R1 standby", 32'(standby), 0);
    chk("R1 pad_out live", 32'(pad_out), 32'h5A);
    chk("R1 pad_oe live", 32'(pad_oe), 32'hF0);
    rst_n = 1'b1;

    // feature off: pd pin is an ordinary input
    rand_run(300, 1'b0, 6);

    // R9 / R10 directed quiet window
    en = 0; pin = 0; pins = 8'h11;
    step();
    pins = 8'h22;
    step();
    for (int k = 0; k < IDLE - 1; k++) step();
    chk("R9 not yet idle", 32'(standby), 0);
    step();
    chk("R9 idle reached", 32'(standby), 1);
    pin = 1;
    step();
    chk("R10 pd pin change wakes when disabled", 32'(standby), 0);

    // R4 / R5 / R6 / R7 / R8 directed freeze
    en = 1; pin = 0;
    repeat (4) step();
    pin = 1; pins = 8'hA1;
    step(); chk("R4 edge1 captures", 32'(core_in), 32'hA1);
    pins = 8'hB2;
    step(); chk("R4 edge2 captures", 32'(core_in), 32'hB2);
    pins = 8'hC3; cout = 8'h3C; coe = 8'h0F;
    step(); chk("R4 edge3 frozen", 32'(core_in), 32'hB2);
    chk("R6 captured at entry", 32'(pad_out), 32'h3C);
    chk("R7 captured at entry", 32'(pad_oe), 32'h0F);
    cout = 8'hFF; coe = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      pins = NI'($urandom);
      step();
      chk("R5 input ignored", 32'(core_in), 32'hB2);
      chk("R6 data held", 32'(pad_out), 32'h3C);
      chk("R7 hi-z kept", 32'(pad_oe), 32'h0F);
    end
    // R10 blocked toggling is not activity
    for (int k = 0; k < IDLE + 2; k++) begin
      pins = ~pins;
      step();
    end
    chk("R10 blocked pins keep standby", 32'(standby), 1);
    pin = 0; pins = 8'hE5;
    step(); chk("R8 still frozen 1", 32'(core_in), 32'hB2);
    step(); chk("R8 still frozen 2", 32'(core_in), 32'hB2);
    step(); chk("R8 released", 32'(core_in), 32'hE5);
    chk("R8 pads live", 32'(pad_out), 32'hFF);
    chk("R10 release change wakes", 32'(standby), 0);

    // feature on: random power-down pulses
    rand_run(1500, 1'b1, 12);
    rand_run(200, 1'b0, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule